// File: doc/BRIEF.md
# Virtually-Indexed Physically-Tagged Cache Tag Lookup

This block is the tag stage of a four-way set-associative first-level cache. The set is chosen from virtual-address bits while the address translation is still in progress. The tags stored in that set are then compared with the physical address that the translation returns. The caller presents the set index taken from the virtual address and the physical line tag in the same cycle. One cycle later the block answers with a hit flag, the way that hit, or a miss flag.

With the default parameters the cache holds 32 KB as 128 sets of four 64-byte lines. The set index is virtual-address bits [12:6]. With 4 KB pages, bit 12 of the index is not guaranteed to match bit 12 of the physical address. For that reason each entry keeps physical bits [31:12], which is one bit more than the [31:13] that index and offset would leave. A line filled under one value of that bit can then never be matched by a lookup for a physical line that differs only in bit 12.

A fill port writes a physical tag into a way of the virtually indexed set. The way comes from a round-robin pointer kept per set and is reported on `fl_way` so that the data array can follow. A flush input clears every valid bit in one cycle. Data storage, refill sequencing and translation are done elsewhere.

Top module: `vipt_tag_lookup`

## Requirements
- R1: After reset `rsp_valid`, `rsp_hit`, `rsp_miss` and `rsp_way` are 0, every entry is invalid, and every set's replacement pointer is at way 0.
- R2: `rsp_valid` is high in exactly the cycle after a cycle with `lk_valid` high. In that cycle exactly one of `rsp_hit` and `rsp_miss` is high. All four response outputs are 0 in every other cycle.
- R3: A lookup hits when a valid entry in set `lk_vidx` holds a tag equal to `lk_ptag` (physical bits [31:12]). `rsp_way` then gives that way as a binary number from 0 to 3.
- R4: A lookup whose `lk_ptag` differs from every valid tag in the set in bits [31:13] misses.
- R5: When a line was filled with physical bit 12 unequal to virtual bit 12, a lookup in that set with physical bits [31:13] equal but physical bit 12 different misses. A lookup for the same physical line through the other set, the one whose index bit 12 differs, also misses.
- R6: Each fill writes the way named on `fl_way`, which is the pointer of set `fl_vidx`. Successive fills into one set use ways 0, 1, 2, 3, 0, and fills into other sets leave that pointer unchanged.
- R7: A cycle with `flush_all` high makes every lookup from the next cycle on miss. A fill in the same cycle is dropped and does not advance its pointer. Replacement pointers are kept across a flush.
- R8: A lookup in the same cycle as a fill to the same set sees the set as it was before the fill. A lookup in the following cycle sees the new line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vidx | input | 7 | Set index from virtual bits [12:6] |
| lk_ptag | input | 20 | Translated physical bits [31:12] |
| fl_valid | input | 1 | Fill request this cycle |
| fl_vidx | input | 7 | Fill set index from virtual bits [12:6] |
| fl_ptag | input | 20 | Physical bits [31:12] of the filled line |
| flush_all | input | 1 | Clear every valid bit |
| rsp_valid | output | 1 | Lookup answer present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_miss | output | 1 | Lookup miss |
| rsp_way | output | 2 | Way that hit, 0 on a miss |
| fl_way | output | 2 | Way the current fill writes |

## Verification
The hardest case to reach is a false alias. It needs a resident line whose physical bit 12 disagrees with the index bit, followed by a lookup whose upper tag bits match and whose bit 12 does not. The stimulus fills set 1 (virtual bit 12 clear) with a physical line that has bit 12 set. It then probes the same set with that bit cleared, and probes set 65 with the original physical line. The other hard cases are fills that wrap the per-set pointer past way 3 and a flush that collides with a fill. Both are reached by fixed sequences whose expected ways follow from the pointer history.

// File: rtl/vipt_pkg.sv
// Package: shared constants and helpers for the VIPT tag lookup.
// Assumes: sizes are powers of two.
package vipt_pkg;
    localparam int unsigned DEF_ADDR_W     = 32;
    localparam int unsigned DEF_LINE_BYTES = 64;
    localparam int unsigned DEF_SETS       = 128;
    localparam int unsigned DEF_WAYS       = 4;
    localparam int unsigned DEF_PAGE_BYTES = 4096;

    // Lowest physical bit kept in a tag: the page boundary when the index
    // reaches above it, otherwise the top of the index.
    function automatic int unsigned tag_low(input int unsigned page_w,
                                            input int unsigned idx_top);
        return (page_w < idx_top) ? page_w : idx_top;
    endfunction
endpackage

// File: rtl/vipt_tag_store.sv
// Module: tag and valid storage, one read port and one write port.
// Read is combinational. A write takes effect at the clock edge, so a
// read in the same cycle returns the old contents. Clearing all valid bits
// wins over a write in the same cycle.
module vipt_tag_store #(
    parameter int unsigned SETS  = 128,
    parameter int unsigned WAYS  = 4,
    parameter int unsigned TAG_W = 20,
    localparam int unsigned IDX_W = $clog2(SETS),
    localparam int unsigned WAY_W = $clog2(WAYS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [IDX_W-1:0]            rd_idx,
    output logic [WAYS-1:0][TAG_W-1:0]  rd_tag,
    output logic [WAYS-1:0]             rd_vld,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [WAY_W-1:0]            wr_way,
    input  logic [TAG_W-1:0]            wr_tag,
    input  logic                        clr_all
);
    logic [TAG_W-1:0]           tag_q [SETS][WAYS];
    logic [SETS-1:0][WAYS-1:0]  vld_q;

    // Tag write; tags need no reset because valid bits gate them.
    always_ff @(posedge clk) begin
        if (wr_en && !clr_all) tag_q[wr_idx][wr_way] <= wr_tag;
    end

    // Valid bits: reset or flush clears all, a fill sets one.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) vld_q <= '0;
        else if (wr_en)        vld_q[wr_idx][wr_way] <= 1'b1;
    end

    // Read the selected set.
    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            rd_tag[w] = tag_q[rd_idx][w];
            rd_vld[w] = vld_q[rd_idx][w];
        end
    end

    // R7
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (vld_q == '0));
    // R6
    fill_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr_all) |=> vld_q[$past(wr_idx)][$past(wr_way)]);
endmodule

// File: rtl/vipt_victim_rr.sv
// Module: one round-robin replacement pointer per set.
// Assumes WAYS is a power of two, so the pointer wraps naturally.
module vipt_victim_rr #(
    parameter int unsigned SETS = 128,
    parameter int unsigned WAYS = 4,
    localparam int unsigned IDX_W = $clog2(SETS),
    localparam int unsigned WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic             fill_en,
    output logic [WAY_W-1:0] victim
);
    logic [SETS-1:0][WAY_W-1:0] ptr_q;

    // Advance the pointer of the filled set.
    always_ff @(posedge clk) begin
        if (!rst_n)       ptr_q <= '0;
        else if (fill_en) ptr_q[fill_idx] <= ptr_q[fill_idx] + 1'b1;
    end

    // Present the victim of the requested set.
    assign victim = ptr_q[fill_idx];

    // R6
    ptr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> (ptr_q[$past(fill_idx)] == WAY_W'($past(victim) + 1'b1)));
    // R6
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_en |=> $stable(ptr_q));
endmodule

// File: rtl/vipt_tag_match.sv
// Module: compares a physical tag with every way of one set and encodes
// the lowest matching valid way. Purely combinational.
module vipt_tag_match #(
    parameter int unsigned WAYS  = 4,
    parameter int unsigned TAG_W = 20,
    localparam int unsigned WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][TAG_W-1:0] set_tag,
    input  logic [WAYS-1:0]            set_vld,
    input  logic [TAG_W-1:0]           ptag,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way
);
    logic [WAYS-1:0] match;

    // One comparator per way.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = set_vld[w] && (set_tag[w] == ptag);
    end

    // Lowest-index priority encode of the match vector.
    always_comb begin
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) hit_way = WAY_W'(w);
        end
    end

    assign hit = |match;
endmodule

// File: rtl/vipt_tag_lookup.sv
// Module: VIPT tag lookup stage. The set comes from virtual bits and the
// compare uses physical bits from the page boundary upward, so lines whose
// physical bit 12 differs are never confused. The answer is registered one
// cycle after the request.
// Assumes: the caller supplies the translated tag in the request cycle.
module vipt_tag_lookup
    import vipt_pkg::*;
#(
    parameter int unsigned ADDR_W     = DEF_ADDR_W,
    parameter int unsigned LINE_BYTES = DEF_LINE_BYTES,
    parameter int unsigned SETS       = DEF_SETS,
    parameter int unsigned WAYS       = DEF_WAYS,
    parameter int unsigned PAGE_BYTES = DEF_PAGE_BYTES,
    localparam int unsigned OFF_W  = $clog2(LINE_BYTES),
    localparam int unsigned IDX_W  = $clog2(SETS),
    localparam int unsigned PG_W   = $clog2(PAGE_BYTES),
    localparam int unsigned TAG_LO = tag_low(PG_W, OFF_W + IDX_W),
    localparam int unsigned TAG_W  = ADDR_W - TAG_LO,
    localparam int unsigned WAY_W  = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [IDX_W-1:0] lk_vidx,
    input  logic [TAG_W-1:0] lk_ptag,
    input  logic             fl_valid,
    input  logic [IDX_W-1:0] fl_vidx,
    input  logic [TAG_W-1:0] fl_ptag,
    input  logic             flush_all,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_miss,
    output logic [WAY_W-1:0] rsp_way,
    output logic [WAY_W-1:0] fl_way
);
    logic [WAYS-1:0][TAG_W-1:0] set_tag;
    logic [WAYS-1:0]            set_vld;
    logic                       cmp_hit;
    logic [WAY_W-1:0]           cmp_way;
    logic                       fill_en;

    assign fill_en = fl_valid && !flush_all;

    vipt_victim_rr #(.SETS(SETS), .WAYS(WAYS)) u_rr (
        .clk(clk), .rst_n(rst_n), .fill_idx(fl_vidx),
        .fill_en(fill_en), .victim(fl_way));

    vipt_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_store (
        .clk(clk), .rst_n(rst_n), .rd_idx(lk_vidx), .rd_tag(set_tag),
        .rd_vld(set_vld), .wr_en(fill_en), .wr_idx(fl_vidx),
        .wr_way(fl_way), .wr_tag(fl_ptag), .clr_all(flush_all));

    vipt_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
        .set_tag(set_tag), .set_vld(set_vld), .ptag(lk_ptag),
        .hit(cmp_hit), .hit_way(cmp_way));

    // Register the lookup answer one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_way   <= '0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= lk_valid && cmp_hit;
            rsp_miss  <= lk_valid && !cmp_hit;
            rsp_way   <= (lk_valid && cmp_hit) ? cmp_way : '0;
        end
    end

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);
    // R2
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!rsp_valid && !rsp_hit && !rsp_miss && rsp_way == '0));
    // R2
    hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_hit, rsp_miss}));
    // R3
    way_zero_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (rsp_way == '0));
endmodule

// File: tb/sim_vipt_tag_lookup.sv
module sim_vipt_tag_lookup;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 18;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_valid, fl_valid, flush_all;
    logic [6:0]  lk_vidx, fl_vidx;
    logic [19:0] lk_ptag, fl_ptag;
    logic        rsp_valid, rsp_hit, rsp_miss;
    logic [1:0]  rsp_way, fl_way;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    vipt_tag_lookup u0 (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vidx(lk_vidx),
        .lk_ptag(lk_ptag), .fl_valid(fl_valid), .fl_vidx(fl_vidx),
        .fl_ptag(fl_ptag), .flush_all(flush_all), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_way(rsp_way),
        .fl_way(fl_way));

    always #(CLK_PERIOD/2) clk = ~clk;

    // {kind (1 = fill), va[31:0], pa[31:0], expect hit, expected way}
    localparam logic [67:0] VEC [NV] = '{
        {1'b0, 32'h0000_0040, 32'h1234_5040, 1'b0, 2'd0}, // R1 empty
        {1'b1, 32'h0000_0040, 32'h1234_5040, 1'b0, 2'd0}, // R6 way0
        {1'b0, 32'h0000_0040, 32'h1234_5040, 1'b1, 2'd0}, // R3
        {1'b0, 32'h0000_007F, 32'h1234_507F, 1'b1, 2'd0}, // R3 offset
        {1'b0, 32'h0000_0040, 32'h1234_4040, 1'b0, 2'd0}, // R5 bit12
        {1'b0, 32'h0000_1040, 32'h1234_5040, 1'b0, 2'd0}, // R5 other set
        {1'b0, 32'h0000_0040, 32'h2234_5040, 1'b0, 2'd0}, // R4
        {1'b1, 32'h0000_0040, 32'h2234_5040, 1'b0, 2'd1}, // R6
        {1'b1, 32'h0000_0040, 32'h3234_5040, 1'b0, 2'd2}, // R6
        {1'b1, 32'h0000_2080, 32'h4000_0080, 1'b0, 2'd0}, // R6 other set
        {1'b1, 32'h0000_0040, 32'h4234_5040, 1'b0, 2'd3}, // R6
        {1'b0, 32'h0000_0040, 32'h3234_5040, 1'b1, 2'd2}, // R3
        {1'b0, 32'h0000_0040, 32'h4234_5040, 1'b1, 2'd3}, // R3
        {1'b0, 32'h0000_0080, 32'h4000_0080, 1'b1, 2'd0}, // R3
        {1'b1, 32'h0000_0040, 32'h5234_5040, 1'b0, 2'd0}, // R6 wrap
        {1'b0, 32'h0000_0040, 32'h1234_5040, 1'b0, 2'd0}, // R4 evicted
        {1'b0, 32'h0000_0040, 32'h5234_5040, 1'b1, 2'd0}, // R3
        {1'b0, 32'h0000_0040, 32'h2234_5040, 1'b1, 2'd1}  // R3
    };

    task automatic check(input bit ok, input string req,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        lk_valid = 1'b0; fl_valid = 1'b0; flush_all = 1'b0;
        lk_vidx = '0; lk_ptag = '0; fl_vidx = '0; fl_ptag = '0;
    endtask

    // Entered at a falling edge; returns at a falling edge.
    task automatic lookup(input logic [31:0] va, input logic [31:0] pa,
                          input bit eh, input logic [1:0] ew, input string req);
        lk_valid = 1'b1; lk_vidx = va[12:6]; lk_ptag = pa[31:12];
        @(negedge clk);
        lk_valid = 1'b0;
        check(rsp_valid && rsp_hit == eh && rsp_miss == !eh && rsp_way == (eh ? ew : 2'd0),
              req, {rsp_valid, rsp_hit, rsp_miss, 3'b0, rsp_way},
              {1'b1, eh, !eh, 3'b0, eh ? ew : 2'd0});
    endtask

    task automatic fill(input logic [31:0] va, input logic [31:0] pa,
                        input logic [1:0] ew, input string req);
        fl_valid = 1'b1; fl_vidx = va[12:6]; fl_ptag = pa[31:12];
        #1;
        check(fl_way == ew, req, {6'b0, fl_way}, {6'b0, ew});
        @(negedge clk);
        fl_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state of the response
        check(!rsp_valid && !rsp_hit && !rsp_miss && rsp_way == 0, "R1",
              {rsp_valid, rsp_hit, rsp_miss, 3'b0, rsp_way}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: no request, no response
        check(!rsp_valid && !rsp_miss, "R2",
              {6'b0, rsp_valid, rsp_miss}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][67])
                fill(VEC[i][66:35], VEC[i][34:3], VEC[i][1:0], "R6 table fill");
            else
                lookup(VEC[i][66:35], VEC[i][34:3], VEC[i][2], VEC[i][1:0],
                       "R3/R4/R5 table lookup");
        end

        // R8: lookup and fill to set 5 in one cycle
        lk_valid = 1'b1; lk_vidx = 7'd5; lk_ptag = 20'h60000;
        fl_valid = 1'b1; fl_vidx = 7'd5; fl_ptag = 20'h60000;
        @(negedge clk);
        idle();
        check(rsp_valid && rsp_miss, "R8 same cycle",
              {6'b0, rsp_valid, rsp_miss}, 8'h03);
        lookup(32'h0000_0140, 32'h6000_0140, 1'b1, 2'd0, "R8 next cycle");

        // R7: flush collides with a fill to set 6
        flush_all = 1'b1; fl_valid = 1'b1; fl_vidx = 7'd6; fl_ptag = 20'h70000;
        @(negedge clk);
        idle();
        lookup(32'h0000_0040, 32'h5234_5040, 1'b0, 2'd0, "R7 flushed set1");
        lookup(32'h0000_0140, 32'h6000_0140, 1'b0, 2'd0, "R7 flushed set5");
        lookup(32'h0000_0180, 32'h7000_0180, 1'b0, 2'd0, "R7 dropped fill");
        fill(32'h0000_0180, 32'h7000_0180, 2'd0, "R7 pointer not advanced");
        fill(32'h0000_0040, 32'h8234_5040, 2'd1, "R7 pointer kept");
        lookup(32'h0000_0040, 32'h8234_5040, 1'b1, 2'd1, "R7 refill hit");

        // R1: reset again clears contents and pointers
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        lookup(32'h0000_0040, 32'h8234_5040, 1'b0, 2'd0, "R1 contents cleared");
        fill(32'h0000_0040, 32'h8234_5040, 2'd0, "R1 pointer cleared");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule